// File: doc/BRIEF.md
# Trap Entry State Save Unit

This block performs the register side of taking a trap. When the pipeline raises a one-cycle trap-taken strobe, it takes a snapshot of the current architectural state and writes the trap-side registers. The saved-state word holds the global level, condition codes, address space identifier, processor state and window pointer. The saved PC and next PC are held beside it, with an optional mask down to 32 bits. The block also stores the old hyper-state and the incoming trap code, and it raises the trap level. It then produces the new processor-state word, hyper-state word, global level and current window pointer for the target mode of the trap.

A 2-bit mode input selects the kind of entry. Code 0 enters the privileged level. Code 1 enters the hyperprivileged level. Code 2 is a reset/error-state (RED) entry. Code 3 is reserved and is ignored. The trap code decides whether the window pointer steps up, steps down, or advances past the saveable windows. All results are registered and are committed together. Vector computation and instruction fetch belong to the surrounding core.

A two-state controller sequences the block. `ST_IDLE` waits for an accepted strobe (transition *accept*: strobe high with a mode other than 3) and moves to `ST_DONE`. `ST_DONE` drives `entry_done` for one cycle. From there it goes to `ST_DONE` again on a new accept, or back to `ST_IDLE` (transition *retire*).

Top module: `trap_entry_unit`

## Requirements
- R1: All outputs change only at the rising edge that samples `trap_take` high with an accepted mode. They capture the inputs present in that cycle and hold while `trap_take` is low. `entry_done` is high in exactly the cycle after each accepted strobe.
- R2: `saved_tstate` holds the global level in bits [42:40], the condition codes in [39:32], the ASI in [31:24], the 13-bit processor state in [20:8] and the window pointer in [4:0]. All other bits are zero.
- R3: When processor-state bit 3 (address mask) is set, `saved_tpc` and `saved_tnpc` keep only bits [31:0] of the PC and next PC, and the upper bits are zero. Otherwise all 64 bits are kept.
- R4: The global level rises by one and saturates. The ceiling is GL_PRIV_MAX (default 2) for mode 0, and GL_HYP_MAX (default 3) for modes 1 and 2.
- R5: For trap code 0x024 the window pointer increments. For codes 0x080–0x0BF it advances by CANSAVE+2. For codes 0x0C0–0x0FF it decrements. Each result wraps modulo NWIN (default 8). Any other code leaves it unchanged.
- R6: Mode 0 sets pef (bit 4) and priv (bit 2), clears am (bit 3) and ie (bit 1), copies tle (bit 8) into cle (bit 9), and keeps mm (bits 7:6) and tle. The hyper-state passes through unchanged.
- R7: Mode 1 sets pef, clears am, ie and cle, and keeps priv, mm and tle. In the hyper-state it clears red (bit 5) and ibe (bit 10), sets hpriv (bit 2), and keeps tlz (bit 0) and all other bits.
- R8: Mode 2 clears the processor state except that it keeps priv and sets pef. In the hyper-state it sets red and hpriv, clears ibe and tlz, and keeps all other bits.
- R9: `saved_htstate` takes the old hyper-state. `new_tt` takes the trap code. `new_tl` becomes the current trap level plus one, saturating at TL_MAX (default 6).
- R10: A strobe with mode 3 changes no output and leaves `entry_done` low.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_take | input | 1 | One-cycle trap-taken strobe |
| trap_mode | input | 2 | Entry kind: 0 privileged, 1 hyperprivileged, 2 RED, 3 reserved |
| trap_code | input | 9 | Incoming trap type |
| cur_pc | input | 64 | PC of the trapping instruction |
| cur_npc | input | 64 | Next PC |
| cur_ccr | input | 8 | Condition codes |
| cur_asi | input | 8 | Address space identifier |
| cur_pstate | input | 13 | Processor state word |
| cur_hpstate | input | 12 | Hyper-state word |
| cur_cwp | input | 5 | Current window pointer |
| cur_cansave | input | 5 | Saveable window count |
| cur_gl | input | 3 | Global register level |
| cur_tl | input | 3 | Trap level |
| entry_done | output | 1 | High in the cycle after an accepted strobe |
| new_tl | output | 3 | Updated trap level |
| new_tt | output | 9 | Recorded trap type |
| saved_tstate | output | 64 | Packed saved-state word |
| saved_tpc | output | 64 | Saved PC |
| saved_tnpc | output | 64 | Saved next PC |
| saved_htstate | output | 12 | Saved hyper-state |
| new_gl | output | 3 | Updated global level |
| new_pstate | output | 13 | Updated processor state |
| new_hpstate | output | 12 | Updated hyper-state |
| new_cwp | output | 5 | Updated window pointer |

## Verification
Every result is registered on the edge of the strobe, so any wrong computation shows at the ports one cycle after that strobe and persists until the next accepted trap. A controller stuck in `ST_DONE` shows as `entry_done` high for two cycles in a row. A wrongly decoded mode or trap-code range shows as a flipped flag bit or an off-by-one window pointer in that same cycle. The directed scenarios cover the window-pointer wrap at both ends, saturation of the global level and trap level, address masking, and the reserved mode. Together these make each of those faults visible at the first check after the strobe.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    // Entry kind selected by trap_mode
    typedef enum logic [1:0] {
        MODE_PRIV  = 2'd0,
        MODE_HYPER = 2'd1,
        MODE_RED   = 2'd2,
        MODE_RSVD  = 2'd3
    } trap_mode_e;

    // Window pointer action chosen from the trap code
    typedef enum logic [1:0] {
        WROT_NONE  = 2'd0,
        WROT_INC   = 2'd1,
        WROT_SPILL = 2'd2,
        WROT_DEC   = 2'd3
    } wrot_e;

    // Controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } entry_state_e;

    // Word widths fixed by the saved-state layout
    localparam int PS_W   = 13;
    localparam int HPS_W  = 12;
    localparam int GL_W   = 3;
    localparam int CCR_W  = 8;
    localparam int ASI_W  = 8;
    localparam int CWP_W  = 5;
    localparam int TS_W   = 64;

    // Processor state bit positions
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    // Hyper-state bit positions
    localparam int HPS_TLZ   = 0;
    localparam int HPS_HPRIV = 2;
    localparam int HPS_RED   = 5;
    localparam int HPS_IBE   = 10;

    // Saved-state field offsets
    localparam int TS_CWP_LO = 0;
    localparam int TS_PS_LO  = 8;
    localparam int TS_ASI_LO = 24;
    localparam int TS_CCR_LO = 32;
    localparam int TS_GL_LO  = 40;

    // Trap code landmarks
    localparam logic [8:0] CODE_CLEAN = 9'h024;

endpackage

// File: rtl/trap_window_rot.sv
module trap_window_rot
    import trap_entry_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int TT_W = 9
) (
    input  logic [TT_W-1:0]  code,
    input  logic [CWP_W-1:0] cwp,
    input  logic [CWP_W-1:0] cansave,
    output logic [CWP_W-1:0] next_cwp
);
    localparam int SUM_W = CWP_W + 2;

    wrot_e            kind;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    // Classify the trap code
    always_comb begin
        kind = WROT_NONE;
        if (code == TT_W'(CODE_CLEAN))
            kind = WROT_INC;
        else if (code[TT_W-1:6] == (TT_W-6)'(2))
            kind = WROT_SPILL;
        else if (code[TT_W-1:6] == (TT_W-6)'(3))
            kind = WROT_DEC;
    end

    // Raw sum before the wrap
    always_comb begin
        unique case (kind)
            WROT_INC:   sum = SUM_W'(cwp) + SUM_W'(1);
            WROT_SPILL: sum = SUM_W'(cwp) + SUM_W'(cansave) + SUM_W'(2);
            WROT_DEC:   sum = SUM_W'(cwp) + SUM_W'(NWIN - 1);
            default:    sum = SUM_W'(cwp);
        endcase
    end

    assign wrapped  = sum % SUM_W'(NWIN);
    assign next_cwp = (kind == WROT_NONE) ? cwp : wrapped[CWP_W-1:0];

endmodule

// File: rtl/trap_state_pack.sv
module trap_state_pack
    import trap_entry_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter int MASK_W = 32
) (
    input  logic [GL_W-1:0]  gl,
    input  logic [CCR_W-1:0] ccr,
    input  logic [ASI_W-1:0] asi,
    input  logic [PS_W-1:0]  pstate,
    input  logic [CWP_W-1:0] cwp,
    input  logic [PC_W-1:0]  pc,
    input  logic [PC_W-1:0]  npc,
    output logic [TS_W-1:0]  tstate,
    output logic [PC_W-1:0]  tpc,
    output logic [PC_W-1:0]  tnpc
);
    localparam int HI_W = PC_W - MASK_W;

    // Pack the saved-state word
    always_comb begin
        tstate = '0;
        tstate[TS_GL_LO  +: GL_W]  = gl;
        tstate[TS_CCR_LO +: CCR_W] = ccr;
        tstate[TS_ASI_LO +: ASI_W] = asi;
        tstate[TS_PS_LO  +: PS_W]  = pstate;
        tstate[TS_CWP_LO +: CWP_W] = cwp;
    end

    // Address mask narrows the return addresses
    always_comb begin
        if (pstate[PS_AM]) begin
            tpc  = {{HI_W{1'b0}}, pc[MASK_W-1:0]};
            tnpc = {{HI_W{1'b0}}, npc[MASK_W-1:0]};
        end else begin
            tpc  = pc;
            tnpc = npc;
        end
    end

endmodule

// File: rtl/trap_status_next.sv
module trap_status_next
    import trap_entry_pkg::*;
#(
    parameter int GL_PRIV_MAX = 2,
    parameter int GL_HYP_MAX  = 3
) (
    input  trap_mode_e       mode,
    input  logic [PS_W-1:0]  pstate,
    input  logic [HPS_W-1:0] hpstate,
    input  logic [GL_W-1:0]  gl,
    output logic [PS_W-1:0]  next_pstate,
    output logic [HPS_W-1:0] next_hpstate,
    output logic [GL_W-1:0]  next_gl
);
    logic [GL_W-1:0] ceil;

    // Global level ceiling depends on the target
    assign ceil    = (mode == MODE_PRIV) ? GL_W'(GL_PRIV_MAX) : GL_W'(GL_HYP_MAX);
    assign next_gl = (gl >= ceil) ? ceil : gl + GL_W'(1);

    always_comb begin
        next_pstate  = pstate;
        next_hpstate = hpstate;
        unique case (mode)
            MODE_PRIV: begin
                next_pstate[PS_PEF]  = 1'b1;
                next_pstate[PS_AM]   = 1'b0;
                next_pstate[PS_IE]   = 1'b0;
                next_pstate[PS_PRIV] = 1'b1;
                next_pstate[PS_CLE]  = pstate[PS_TLE];
            end
            MODE_HYPER: begin
                next_pstate[PS_PEF]     = 1'b1;
                next_pstate[PS_AM]      = 1'b0;
                next_pstate[PS_IE]      = 1'b0;
                next_pstate[PS_CLE]     = 1'b0;
                next_hpstate[HPS_RED]   = 1'b0;
                next_hpstate[HPS_HPRIV] = 1'b1;
                next_hpstate[HPS_IBE]   = 1'b0;
            end
            MODE_RED: begin
                next_pstate             = '0;
                next_pstate[PS_PRIV]    = pstate[PS_PRIV];
                next_pstate[PS_PEF]     = 1'b1;
                next_hpstate[HPS_RED]   = 1'b1;
                next_hpstate[HPS_HPRIV] = 1'b1;
                next_hpstate[HPS_IBE]   = 1'b0;
                next_hpstate[HPS_TLZ]   = 1'b0;
            end
            default: begin
                next_pstate  = pstate;
                next_hpstate = hpstate;
            end
        endcase
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int NWIN        = 8,
    parameter int GL_PRIV_MAX = 2,
    parameter int GL_HYP_MAX  = 3,
    parameter int TL_W        = 3,
    parameter int TL_MAX      = 6,
    parameter int TT_W        = 9,
    parameter int PC_W        = 64,
    parameter int MASK_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_take,
    input  logic [1:0]        trap_mode,
    input  logic [TT_W-1:0]   trap_code,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   cur_npc,
    input  logic [7:0]        cur_ccr,
    input  logic [7:0]        cur_asi,
    input  logic [12:0]       cur_pstate,
    input  logic [11:0]       cur_hpstate,
    input  logic [4:0]        cur_cwp,
    input  logic [4:0]        cur_cansave,
    input  logic [2:0]        cur_gl,
    input  logic [TL_W-1:0]   cur_tl,
    output logic              entry_done,
    output logic [TL_W-1:0]   new_tl,
    output logic [TT_W-1:0]   new_tt,
    output logic [63:0]       saved_tstate,
    output logic [PC_W-1:0]   saved_tpc,
    output logic [PC_W-1:0]   saved_tnpc,
    output logic [11:0]       saved_htstate,
    output logic [2:0]        new_gl,
    output logic [12:0]       new_pstate,
    output logic [11:0]       new_hpstate,
    output logic [4:0]        new_cwp
);
    trap_mode_e       mode;
    logic             accept;
    entry_state_e     state_q, state_d;

    logic [TS_W-1:0]  ts_c;
    logic [PC_W-1:0]  tpc_c, tnpc_c;
    logic [PS_W-1:0]  ps_c;
    logic [HPS_W-1:0] hps_c;
    logic [GL_W-1:0]  gl_c;
    logic [CWP_W-1:0] cwp_c;
    logic [TL_W-1:0]  tl_c;

    assign mode   = trap_mode_e'(trap_mode);
    assign accept = trap_take && (mode != MODE_RSVD);
    assign tl_c   = (cur_tl >= TL_W'(TL_MAX)) ? TL_W'(TL_MAX) : cur_tl + TL_W'(1);

    trap_state_pack #(.PC_W(PC_W), .MASK_W(MASK_W)) u_pack (
        .gl     (cur_gl),
        .ccr    (cur_ccr),
        .asi    (cur_asi),
        .pstate (cur_pstate),
        .cwp    (cur_cwp),
        .pc     (cur_pc),
        .npc    (cur_npc),
        .tstate (ts_c),
        .tpc    (tpc_c),
        .tnpc   (tnpc_c)
    );

    trap_status_next #(.GL_PRIV_MAX(GL_PRIV_MAX), .GL_HYP_MAX(GL_HYP_MAX)) u_status (
        .mode         (mode),
        .pstate       (cur_pstate),
        .hpstate      (cur_hpstate),
        .gl           (cur_gl),
        .next_pstate  (ps_c),
        .next_hpstate (hps_c),
        .next_gl      (gl_c)
    );

    trap_window_rot #(.NWIN(NWIN), .TT_W(TT_W)) u_rot (
        .code     (trap_code),
        .cwp      (cur_cwp),
        .cansave  (cur_cansave),
        .next_cwp (cwp_c)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = accept ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        entry_done = (state_q == ST_DONE);
    end

    // Architectural register commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_tl        <= '0;
            new_tt        <= '0;
            saved_tstate  <= '0;
            saved_tpc     <= '0;
            saved_tnpc    <= '0;
            saved_htstate <= '0;
            new_gl        <= '0;
            new_pstate    <= '0;
            new_hpstate   <= '0;
            new_cwp       <= '0;
        end else if (accept) begin
            new_tl        <= tl_c;
            new_tt        <= trap_code;
            saved_tstate  <= ts_c;
            saved_tpc     <= tpc_c;
            saved_tnpc    <= tnpc_c;
            saved_htstate <= cur_hpstate;
            new_gl        <= gl_c;
            new_pstate    <= ps_c;
            new_hpstate   <= hps_c;
            new_cwp       <= cwp_c;
        end
    end

    AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && trap_mode != 2'd3) |=> entry_done); // R1
    AST_HOLD_WITHOUT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_take |=> ($stable(saved_tstate) && $stable(new_cwp) && $stable(new_gl) && $stable(new_tl))); // R1
    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_take && trap_mode == 2'd3) |=> (!entry_done && $stable(new_pstate) && $stable(new_tt))); // R10
    AST_PC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done && $past(cur_pstate[PS_AM])) |-> (saved_tpc[PC_W-1:MASK_W] == '0 && saved_tnpc[PC_W-1:MASK_W] == '0)); // R3
    AST_PRIV_GL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done && $past(trap_mode) == 2'd0) |-> (new_gl <= 3'(GL_PRIV_MAX))); // R4
    AST_CWP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done && $past(cur_cwp) < 5'(NWIN)) |-> (new_cwp < 5'(NWIN))); // R5
    AST_HYPER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done && $past(trap_mode) == 2'd1) |-> (new_hpstate[HPS_HPRIV] && !new_hpstate[HPS_RED] && !new_hpstate[HPS_IBE])); // R7
    AST_RED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done && $past(trap_mode) == 2'd2) |-> (new_hpstate[HPS_RED] && new_hpstate[HPS_HPRIV] && !new_hpstate[HPS_TLZ])); // R8

endmodule

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_take = 1'b0;
    logic [1:0]  trap_mode = '0;
    logic [8:0]  trap_code = '0;
    logic [63:0] cur_pc = '0, cur_npc = '0;
    logic [7:0]  cur_ccr = '0, cur_asi = '0;
    logic [12:0] cur_pstate = '0;
    logic [11:0] cur_hpstate = '0;
    logic [4:0]  cur_cwp = '0, cur_cansave = '0;
    logic [2:0]  cur_gl = '0, cur_tl = '0;

    logic        entry_done;
    logic [2:0]  new_tl, new_gl;
    logic [8:0]  new_tt;
    logic [63:0] saved_tstate, saved_tpc, saved_tnpc;
    logic [11:0] saved_htstate, new_hpstate;
    logic [12:0] new_pstate;
    logic [4:0]  new_cwp;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    trap_entry_unit uut (
        .clk(clk), .rst_n(rst_n), .trap_take(trap_take), .trap_mode(trap_mode),
        .trap_code(trap_code), .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr),
        .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_hpstate(cur_hpstate),
        .cur_cwp(cur_cwp), .cur_cansave(cur_cansave), .cur_gl(cur_gl), .cur_tl(cur_tl),
        .entry_done(entry_done), .new_tl(new_tl), .new_tt(new_tt),
        .saved_tstate(saved_tstate), .saved_tpc(saved_tpc), .saved_tnpc(saved_tnpc),
        .saved_htstate(saved_htstate), .new_gl(new_gl), .new_pstate(new_pstate),
        .new_hpstate(new_hpstate), .new_cwp(new_cwp)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_ts(input logic [2:0] g, input logic [7:0] c,
                                            input logic [7:0] a, input logic [12:0] p, input logic [4:0] w);
        return ({61'd0, g} << 40) | ({56'd0, c} << 32) | ({56'd0, a} << 24) | ({51'd0, p} << 8) | {59'd0, w};
    endfunction

    // Drive one strobe; results are sampled on the following falling edge
    task automatic fire(input logic [1:0] m, input logic [8:0] code);
        @(negedge clk);
        trap_mode = m;
        trap_code = code;
        trap_take = 1'b1;
        @(negedge clk);
        trap_take = 1'b0;
    endtask

    task automatic set_state(input logic [63:0] pc, input logic [7:0] ccr, input logic [7:0] asi,
                             input logic [12:0] ps, input logic [11:0] hps, input logic [4:0] cwp,
                             input logic [4:0] cs, input logic [2:0] gl, input logic [2:0] tl);
        cur_pc = pc; cur_npc = pc + 64'd4; cur_ccr = ccr; cur_asi = asi;
        cur_pstate = ps; cur_hpstate = hps; cur_cwp = cwp; cur_cansave = cs;
        cur_gl = gl; cur_tl = tl;
    endtask

    task automatic t_reset;
        chk("R11", "entry_done", {63'd0, entry_done}, 64'd0);
        chk("R11", "tstate", saved_tstate, 64'd0);
        chk("R11", "pstate/cwp/gl", {38'd0, new_pstate, new_cwp, new_gl, new_tl}, 64'd0);
    endtask

    task automatic t_priv_clean;
        set_state(64'h1234_5678_9ABC_DEF0, 8'hA5, 8'h3C, 13'h182, 12'h0C3, 5'd3, 5'd2, 3'd1, 3'd1);
        fire(2'd0, 9'h024);
        chk("R1", "entry_done", {63'd0, entry_done}, 64'd1);
        chk("R2", "tstate", saved_tstate, pack_ts(3'd1, 8'hA5, 8'h3C, 13'h182, 5'd3));
        chk("R3", "tpc unmasked", saved_tpc, 64'h1234_5678_9ABC_DEF0);
        chk("R3", "tnpc unmasked", saved_tnpc, 64'h1234_5678_9ABC_DEF4);
        chk("R5", "cwp inc", {59'd0, new_cwp}, 64'd4);
        chk("R4", "gl inc", {61'd0, new_gl}, 64'd2);
        chk("R6", "pstate", {51'd0, new_pstate}, 64'h394);
        chk("R6", "hpstate kept", {52'd0, new_hpstate}, 64'h0C3);
        chk("R9", "htstate", {52'd0, saved_htstate}, 64'h0C3);
        chk("R9", "tt", {55'd0, new_tt}, 64'h024);
        chk("R9", "tl", {61'd0, new_tl}, 64'd2);
        @(negedge clk);
        chk("R1", "done one cycle", {63'd0, entry_done}, 64'd0);
    endtask

    task automatic t_hold;
        set_state(64'hFFFF_0000_FFFF_0000, 8'h11, 8'h22, 13'h0, 12'h0, 5'd6, 5'd1, 3'd0, 3'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R1", "tstate held", saved_tstate, pack_ts(3'd1, 8'hA5, 8'h3C, 13'h182, 5'd3));
        chk("R1", "cwp held", {59'd0, new_cwp}, 64'd4);
    endtask

    task automatic t_priv_mask_dec;
        set_state(64'hDEAD_BEEF_0000_1000, 8'h01, 8'h02, 13'h008, 12'h000, 5'd0, 5'd0, 3'd2, 3'd0);
        fire(2'd0, 9'h0C5);
        chk("R3", "tpc masked", saved_tpc, 64'h0000_0000_0000_1000);
        chk("R3", "tnpc masked", saved_tnpc, 64'h0000_0000_0000_1004);
        chk("R5", "cwp dec wrap", {59'd0, new_cwp}, 64'd7);
        chk("R4", "gl priv ceiling", {61'd0, new_gl}, 64'd2);
        chk("R6", "pstate am cleared", {51'd0, new_pstate}, 64'h014);
    endtask

    task automatic t_hyper_spill;
        set_state(64'h0000_0001_0000_0040, 8'hFF, 8'h80, 13'h20E, 12'h429, 5'd6, 5'd3, 3'd2, 3'd3);
        fire(2'd1, 9'h090);
        chk("R5", "cwp spill", {59'd0, new_cwp}, 64'd3);
        chk("R4", "gl hyper inc", {61'd0, new_gl}, 64'd3);
        chk("R7", "pstate", {51'd0, new_pstate}, 64'h014);
        chk("R7", "hpstate", {52'd0, new_hpstate}, 64'h00D);
        chk("R9", "htstate", {52'd0, saved_htstate}, 64'h429);
        chk("R9", "tl", {61'd0, new_tl}, 64'd4);
        set_state(64'h40, 8'h00, 8'h00, 13'h000, 12'h000, 5'd7, 5'd7, 3'd3, 3'd0);
        fire(2'd1, 9'h0BF);
        chk("R5", "cwp spill wrap", {59'd0, new_cwp}, 64'd0);
        chk("R4", "gl hyper ceiling", {61'd0, new_gl}, 64'd3);
    endtask

    task automatic t_red;
        set_state(64'h8000_0000_0000_0000, 8'h5A, 8'h04, 13'h1FFF, 12'h481, 5'd5, 5'd0, 3'd2, 3'd6);
        fire(2'd2, 9'h0E0);
        chk("R8", "pstate", {51'd0, new_pstate}, 64'h014);
        chk("R8", "hpstate", {52'd0, new_hpstate}, 64'h0A4);
        chk("R4", "gl red", {61'd0, new_gl}, 64'd3);
        chk("R5", "cwp dec", {59'd0, new_cwp}, 64'd4);
        chk("R9", "tl saturate", {61'd0, new_tl}, 64'd6);
        chk("R2", "tstate", saved_tstate, pack_ts(3'd2, 8'h5A, 8'h04, 13'h1FFF, 5'd5));
        set_state(64'h10, 8'h00, 8'h00, 13'h1FFB, 12'h000, 5'd5, 5'd0, 3'd3, 3'd1);
        fire(2'd2, 9'h100);
        chk("R8", "pstate priv clear", {51'd0, new_pstate}, 64'h010);
        chk("R5", "cwp unchanged", {59'd0, new_cwp}, 64'd5);
        chk("R9", "tt", {55'd0, new_tt}, 64'h100);
    endtask

    task automatic t_rsvd;
        set_state(64'h77, 8'h33, 8'h44, 13'h0AA, 12'h055, 5'd1, 5'd1, 3'd0, 3'd0);
        fire(2'd3, 9'h024);
        chk("R10", "no done", {63'd0, entry_done}, 64'd0);
        chk("R10", "tt kept", {55'd0, new_tt}, 64'h100);
        chk("R10", "pstate kept", {51'd0, new_pstate}, 64'h010);
        chk("R10", "cwp kept", {59'd0, new_cwp}, 64'd5);
    endtask

    initial begin
        #10000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_priv_clean();
        t_hold();
        t_priv_mask_dec();
        t_hyper_spill();
        t_red();
        t_rsvd();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule